// File: doc/BRIEF.md
# Dual-Clock True Dual-Port RAM with Output Pipeline

This block is a synchronous memory with two complete, independent ports. Each port has its own clock, enable, byte-lane write enables, address, write data and read data. Both ports share one storage array, so a word written through one port can be read through the other, even when the two clocks are unrelated. Each port is used like an ordinary synchronous RAM port. The address and controls are presented before a rising edge, and read data returns after that edge.

Each port has several build-time choices. A write-mode parameter sets what the port shows on its output during its own write. An optional pipeline register adds one cycle of latency in return for a cleaner clock-to-output path. Two synchronous resets are provided: one forces the read latch and the other forces the pipeline register. A priority parameter sets whether the register reset needs the register clock enable to act. The reset value and the power-up output value are also parameters.

Top module: `dp_ram_pipe`

## Requirements
- R1: After power-up and before any read or reset, each port output equals that port's INIT parameter.
- R2: With the pipeline register disabled, the word at the address presented with enable high is on the output after that rising edge.
- R3: Write-enable bit i updates only data bits [8i+7:8i] of the addressed word; lanes whose bit is low keep their stored contents.
- R4: In write mode 0 (write-first), a write shows on the output the stored word as it is after the write, with disabled lanes holding their old contents.
- R5: In write mode 1 (read-first), a write shows on the output the contents the address held before the write.
- R6: In write mode 2 (no-change), the output keeps its previous value during a write, and the write is still stored.
- R7: With enable low, nothing is read or written, and the read latch holds its value unless the latch reset is high.
- R8: With the pipeline register enabled, read data arrives one edge later than the read latch, and the register holds its value while its clock enable is low.
- R9: The latch reset loads the read latch with SRVAL regardless of enable, while a write in the same cycle is still stored. With the pipeline register enabled, SRVAL reaches the output at the next register-enabled edge.
- R10: The register reset loads the pipeline register with SRVAL. With priority 0 it acts whatever the register clock enable is; with priority 1 it acts only when the register clock enable is high.
- R11: A word written through one port is read back through the other port, with each port running on its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock, rising edge |
| en_a | input | 1 | Port A access enable |
| we_a | input | DATA_W/8 | Port A byte-lane write enables |
| addr_a | input | log2(DEPTH) | Port A word address |
| din_a | input | DATA_W | Port A write data |
| lat_rst_a | input | 1 | Port A read-latch synchronous reset |
| reg_rst_a | input | 1 | Port A pipeline-register synchronous reset |
| reg_ce_a | input | 1 | Port A pipeline-register clock enable |
| dout_a | output | DATA_W | Port A read data |
| clk_b | input | 1 | Port B clock, rising edge |
| en_b | input | 1 | Port B access enable |
| we_b | input | DATA_W/8 | Port B byte-lane write enables |
| addr_b | input | log2(DEPTH) | Port B word address |
| din_b | input | DATA_W | Port B write data |
| lat_rst_b | input | 1 | Port B read-latch synchronous reset |
| reg_rst_b | input | 1 | Port B pipeline-register synchronous reset |
| reg_ce_b | input | 1 | Port B pipeline-register clock enable |
| dout_b | output | DATA_W | Port B read data |

## Verification
Two pairs of functions can land on the same edge, and the bench provokes both. First, a write and the read of the same port: each port writes an address whose old contents are already known, and the next output must be the new word, the old word, or the unchanged previous output, depending on the write mode. Second, the register reset and the register clock enable: the register reset is pulsed once with the clock enable low and once with it high, on one port set to each priority. The outcome is judged by whether SRVAL or the earlier value is visible on the following edge.

// File: rtl/dp_ram_pipe.sv
module dp_ram_pipe #(
  parameter int DEPTH     = 1024,
  parameter int DATA_W    = 32,
  parameter int MODE_A    = 0,
  parameter int MODE_B    = 1,
  parameter int OUT_REG_A = 1,
  parameter int OUT_REG_B = 1,
  parameter int PRIO_A    = 0,
  parameter int PRIO_B    = 1,
  parameter logic [DATA_W-1:0] SRVAL_A = '0,
  parameter logic [DATA_W-1:0] SRVAL_B = '0,
  parameter logic [DATA_W-1:0] INIT_A  = '0,
  parameter logic [DATA_W-1:0] INIT_B  = '0,
  localparam int AW    = $clog2(DEPTH),
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk_a,
  input  logic              en_a,
  input  logic [LANES-1:0]  we_a,
  input  logic [AW-1:0]     addr_a,
  input  logic [DATA_W-1:0] din_a,
  input  logic              lat_rst_a,
  input  logic              reg_rst_a,
  input  logic              reg_ce_a,
  output logic [DATA_W-1:0] dout_a,
  input  logic              clk_b,
  input  logic              en_b,
  input  logic [LANES-1:0]  we_b,
  input  logic [AW-1:0]     addr_b,
  input  logic [DATA_W-1:0] din_b,
  input  logic              lat_rst_b,
  input  logic              reg_rst_b,
  input  logic              reg_ce_b,
  output logic [DATA_W-1:0] dout_b
);

  // Stored word = bank_a ^ bank_b; each bank has a single writer.
  logic [DATA_W-1:0] bank_a [DEPTH];
  logic [DATA_W-1:0] bank_b [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      bank_a[i] = '0;
      bank_b[i] = '0;
    end
  end

  always_ff @(posedge clk_a)
    if (en_a)
      for (int l = 0; l < LANES; l++)
        if (we_a[l])
          bank_a[addr_a][l*8 +: 8] <= din_a[l*8 +: 8] ^ bank_b[addr_a][l*8 +: 8];

  always_ff @(posedge clk_b)
    if (en_b)
      for (int l = 0; l < LANES; l++)
        if (we_b[l])
          bank_b[addr_b][l*8 +: 8] <= din_b[l*8 +: 8] ^ bank_a[addr_b][l*8 +: 8];

  logic [1:0]        clk_v, en_v, lrst_v, rrst_v, ce_v;
  logic [LANES-1:0]  we_v   [2];
  logic [AW-1:0]     addr_v [2];
  logic [DATA_W-1:0] din_v  [2];
  logic [DATA_W-1:0] dout_v [2];

  assign clk_v  = {clk_b, clk_a};
  assign en_v   = {en_b, en_a};
  assign lrst_v = {lat_rst_b, lat_rst_a};
  assign rrst_v = {reg_rst_b, reg_rst_a};
  assign ce_v   = {reg_ce_b, reg_ce_a};
  assign we_v[0]   = we_a;
  assign we_v[1]   = we_b;
  assign addr_v[0] = addr_a;
  assign addr_v[1] = addr_b;
  assign din_v[0]  = din_a;
  assign din_v[1]  = din_b;
  assign dout_a    = dout_v[0];
  assign dout_b    = dout_v[1];

  for (genvar p = 0; p < 2; p++) begin : g_port
    localparam int MODE = (p == 0) ? MODE_A : MODE_B;
    localparam int OREG = (p == 0) ? OUT_REG_A : OUT_REG_B;
    localparam int PRIO = (p == 0) ? PRIO_A : PRIO_B;
    localparam logic [DATA_W-1:0] SRV = (p == 0) ? SRVAL_A : SRVAL_B;
    localparam logic [DATA_W-1:0] INI = (p == 0) ? INIT_A : INIT_B;

    logic [DATA_W-1:0] cur, merged;
    logic [DATA_W-1:0] lat   = INI;
    logic              armed = 1'b0;
    logic              wr_any;

    assign cur    = bank_a[addr_v[p]] ^ bank_b[addr_v[p]];
    assign wr_any = en_v[p] && (|we_v[p]);

    always_comb
      for (int l = 0; l < LANES; l++)
        merged[l*8 +: 8] = we_v[p][l] ? din_v[p][l*8 +: 8] : cur[l*8 +: 8];

    always_ff @(posedge clk_v[p]) begin
      armed <= 1'b1;
      if (lrst_v[p])         lat <= SRV;
      else if (en_v[p]) begin
        if (!wr_any)         lat <= cur;
        else if (MODE == 0)  lat <= merged;
        else if (MODE == 1)  lat <= cur;
      end
    end

    a_r9_latch_reset: assert property (@(posedge clk_v[p]) disable iff (!armed)
      lrst_v[p] |=> lat == SRV);
    a_r7_idle_hold: assert property (@(posedge clk_v[p]) disable iff (!armed)
      !en_v[p] && !lrst_v[p] |=> $stable(lat));

    if (MODE == 0) begin : g_wf
      a_r4_write_first: assert property (@(posedge clk_v[p]) disable iff (!armed)
        en_v[p] && (&we_v[p]) && !lrst_v[p] |=> lat == $past(din_v[p]));
    end else if (MODE == 1) begin : g_rf
      a_r5_read_first: assert property (@(posedge clk_v[p]) disable iff (!armed)
        wr_any && !lrst_v[p] |=> lat == $past(cur));
    end else begin : g_nc
      a_r6_no_change: assert property (@(posedge clk_v[p]) disable iff (!armed)
        wr_any && !lrst_v[p] |=> $stable(lat));
    end

    if (OREG != 0) begin : g_reg
      logic [DATA_W-1:0] q = INI;
      always_ff @(posedge clk_v[p]) begin
        if (PRIO == 0) begin
          if (rrst_v[p])     q <= SRV;
          else if (ce_v[p])  q <= lat;
        end else if (ce_v[p]) begin
          q <= rrst_v[p] ? SRV : lat;
        end
      end
      assign dout_v[p] = q;

      a_r8_reg_hold: assert property (@(posedge clk_v[p]) disable iff (!armed)
        !ce_v[p] && (PRIO != 0 || !rrst_v[p]) |=> $stable(q));
      a_r10_reg_reset: assert property (@(posedge clk_v[p]) disable iff (!armed)
        rrst_v[p] && (PRIO == 0 || ce_v[p]) |=> q == SRV);
    end else begin : g_noreg
      assign dout_v[p] = lat;
    end
  end

endmodule

// File: tb/dp_ram_pipe_tb.sv
`timescale 1ns/1ps
module dp_ram_pipe_tb;
  logic clk_a = 0, clk_b = 0;
  always #2 clk_a = ~clk_a;
  always #3 clk_b = ~clk_b;

  int checks = 0, fails = 0;
  bit done = 0;

  logic en_a = 0, lrst_a = 0;
  logic [1:0] we_a = 0;
  logic [3:0] addr_a = 0;
  logic [15:0] din_a = 0, dout_a;
  logic en_b = 0, lrst_b = 0, rrst_b = 0, ce_b = 1;
  logic [1:0] we_b = 0;
  logic [3:0] addr_b = 0;
  logic [15:0] din_b = 0, dout_b;
  logic en_c = 0, rrst_c = 0, ce_c = 0;
  logic [1:0] we_c = 0;
  logic [3:0] addr_c = 0;
  logic [15:0] din_c = 0, dout_c, dout_d;

  dp_ram_pipe #(.DEPTH(16), .DATA_W(16), .MODE_A(0), .MODE_B(1),
    .OUT_REG_A(0), .OUT_REG_B(1), .PRIO_A(0), .PRIO_B(0),
    .SRVAL_A(16'h5A5A), .SRVAL_B(16'hA5A5), .INIT_A(16'h1234), .INIT_B(16'h4321)) u_dut (
    .clk_a(clk_a), .en_a(en_a), .we_a(we_a), .addr_a(addr_a), .din_a(din_a),
    .lat_rst_a(lrst_a), .reg_rst_a(1'b0), .reg_ce_a(1'b0), .dout_a(dout_a),
    .clk_b(clk_b), .en_b(en_b), .we_b(we_b), .addr_b(addr_b), .din_b(din_b),
    .lat_rst_b(lrst_b), .reg_rst_b(rrst_b), .reg_ce_b(ce_b), .dout_b(dout_b));

  dp_ram_pipe #(.DEPTH(16), .DATA_W(16), .MODE_A(2), .MODE_B(0),
    .OUT_REG_A(1), .OUT_REG_B(0), .PRIO_A(1), .PRIO_B(0),
    .SRVAL_A(16'hBEEF), .INIT_A(16'hCAFE)) u_dut2 (
    .clk_a(clk_a), .en_a(en_c), .we_a(we_c), .addr_a(addr_c), .din_a(din_c),
    .lat_rst_a(1'b0), .reg_rst_a(rrst_c), .reg_ce_a(ce_c), .dout_a(dout_c),
    .clk_b(clk_b), .en_b(1'b0), .we_b(2'b00), .addr_b(4'd0), .din_b(16'h0),
    .lat_rst_b(1'b0), .reg_rst_b(1'b0), .reg_ce_b(1'b0), .dout_b(dout_d));

  // {we, addr, din, expected dout_a} for the write-first port without register
  localparam logic [37:0] VEC [8] = '{
    {2'b11, 4'd1, 16'h1111, 16'h1111},
    {2'b11, 4'd2, 16'h2222, 16'h2222},
    {2'b00, 4'd1, 16'h0000, 16'h1111},
    {2'b01, 4'd2, 16'hABCD, 16'h22CD},
    {2'b10, 4'd1, 16'h77EE, 16'h7711},
    {2'b00, 4'd2, 16'h0000, 16'h22CD},
    {2'b00, 4'd1, 16'h0000, 16'h7711},
    {2'b11, 4'd3, 16'h0F0F, 16'h0F0F}
  };

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op_a(input logic e, input logic [1:0] w, input logic [3:0] ad,
                      input logic [15:0] d, input logic rl);
    @(negedge clk_a); en_a = e; we_a = w; addr_a = ad; din_a = d; lrst_a = rl;
    @(negedge clk_a); en_a = 0; we_a = 0; lrst_a = 0;
  endtask

  task automatic op_b(input logic e, input logic [1:0] w, input logic [3:0] ad,
                      input logic [15:0] d, input logic rl, input logic rr,
                      input logic ce_op, input logic ce_idle);
    @(negedge clk_b); en_b = e; we_b = w; addr_b = ad; din_b = d;
    lrst_b = rl; rrst_b = rr; ce_b = ce_op;
    @(negedge clk_b); en_b = 0; we_b = 0; lrst_b = 0; rrst_b = 0; ce_b = ce_idle;
  endtask

  task automatic op_c(input logic e, input logic [1:0] w, input logic [3:0] ad,
                      input logic [15:0] d, input logic rr,
                      input logic ce_op, input logic ce_idle);
    @(negedge clk_a); en_c = e; we_c = w; addr_c = ad; din_c = d; rrst_c = rr; ce_c = ce_op;
    @(negedge clk_a); en_c = 0; we_c = 0; rrst_c = 0; ce_c = ce_idle;
  endtask

  initial begin
    #1;
    chk(dout_a, 16'h1234, "R1 power-up port A");
    chk(dout_b, 16'h4321, "R1 power-up port B");
    chk(dout_c, 16'hCAFE, "R1 power-up registered port");

    for (int i = 0; i < 8; i++) begin
      op_a(1'b1, VEC[i][37:36], VEC[i][35:32], VEC[i][31:16], 1'b0);
      chk(dout_a, VEC[i][15:0],
          VEC[i][37:36] == 2'b00 ? "R2 read" : (VEC[i][37:36] == 2'b11 ? "R4 write-first" : "R3 lane write"));
    end

    op_a(1'b0, 2'b11, 4'd2, 16'hFFFF, 1'b0);
    chk(dout_a, 16'h0F0F, "R7 disabled port holds output");
    op_a(1'b1, 2'b00, 4'd2, 16'h0000, 1'b0);
    chk(dout_a, 16'h22CD, "R7 disabled write not stored");

    op_a(1'b1, 2'b11, 4'd4, 16'h4444, 1'b1);
    chk(dout_a, 16'h5A5A, "R9 latch reset");
    op_a(1'b1, 2'b00, 4'd4, 16'h0000, 1'b0);
    chk(dout_a, 16'h4444, "R9 write during latch reset stored");

    op_b(1'b1, 2'b00, 4'd1, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk(dout_b, 16'h4321, "R8 register adds one cycle");
    @(negedge clk_b);
    chk(dout_b, 16'h7711, "R11 port B reads port A data");

    op_b(1'b1, 2'b11, 4'd1, 16'h9999, 1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk_b);
    chk(dout_b, 16'h7711, "R5 read-first shows old word");
    op_a(1'b1, 2'b00, 4'd1, 16'h0000, 1'b0);
    chk(dout_a, 16'h9999, "R11 port A reads port B data");

    op_b(1'b1, 2'b00, 4'd2, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk_b);
    chk(dout_b, 16'h22CD, "R8 registered read");

    op_b(1'b0, 2'b00, 4'd0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b1);
    chk(dout_b, 16'hA5A5, "R10 reset wins without clock enable");
    @(negedge clk_b);
    chk(dout_b, 16'h22CD, "R10 register reloads latch");

    op_b(1'b1, 2'b00, 4'd3, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(dout_b, 16'h22CD, "R8 hold with clock enable low");
    @(negedge clk_b);
    chk(dout_b, 16'h22CD, "R8 hold second cycle");

    op_b(1'b0, 2'b00, 4'd0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b1);
    chk(dout_b, 16'h22CD, "R9 latch reset not yet at output");
    @(negedge clk_b);
    chk(dout_b, 16'hA5A5, "R9 latch reset through register");

    op_c(1'b1, 2'b11, 4'd5, 16'h5555, 1'b0, 1'b1, 1'b1);
    @(negedge clk_a);
    chk(dout_c, 16'hCAFE, "R6 no-change keeps output");
    op_c(1'b1, 2'b00, 4'd5, 16'h0, 1'b0, 1'b1, 1'b1);
    @(negedge clk_a);
    chk(dout_c, 16'h5555, "R8 registered read of no-change port");
    op_c(1'b1, 2'b11, 4'd5, 16'h6666, 1'b0, 1'b1, 1'b1);
    @(negedge clk_a);
    chk(dout_c, 16'h5555, "R6 no-change on overwrite");
    op_c(1'b0, 2'b00, 4'd0, 16'h0, 1'b1, 1'b0, 1'b0);
    chk(dout_c, 16'h5555, "R10 gated reset ignored without clock enable");
    op_c(1'b0, 2'b00, 4'd0, 16'h0, 1'b1, 1'b1, 1'b0);
    chk(dout_c, 16'hBEEF, "R10 gated reset with clock enable");
    op_c(1'b1, 2'b00, 4'd5, 16'h0, 1'b0, 1'b1, 1'b1);
    @(negedge clk_a);
    chk(dout_c, 16'h6666, "R6 no-change write was stored");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_a);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule